// File: doc/BRIEF.md
# Pixel Hit Time Capture Cell

This block is the digital part of one cell in a hybrid pixel readout matrix. It receives the comparator output of the cell's analog front-end, already brought into the clock domain, together with a shutter signal and the reference clock. Inside each shutter window it detects the first upward crossing of the comparator. From that crossing it measures two things: the arrival time, counted from the crossing until the shutter closes, and the pulse duration, counted while the comparator stays high. Both counts are 4 bits wide and stop at their top value instead of wrapping. A sticky hit flag marks that the cell holds data.

Before each exposure the periphery pulses a synchronous clear. After the shutter closes it pulses a load. The load copies the 9-bit word {flag, arrival, duration} into a readout register, which a shift chain or column bus then drains. A cell with no hit gives a word of all zeros, and the readout logic can skip it. The cell also holds the 4-bit threshold-trim code for its trim DAC in a small configuration register, which the clear does not touch.

Top module: `pix_hit_capture`

## Requirements
- R1: While rst_ni is low, and at its release, rd_word_o, hit_o and trim_o are all zero.
- R2: Arrival count: it becomes 1 on the clock edge that samples the first rising comparator edge (disc_i high after a low sample) with shutter_i high. It then rises by 1 on each later edge that samples shutter_i high. It freezes after the first edge that samples shutter_i low, and stays frozen even if the shutter reopens before a clear.
- R3: Duration count: it becomes 1 on that same edge. It then rises by 1 on each later edge that samples both disc_i and shutter_i high. It freezes for good at the first edge that samples either one low, so later pulses in the window are not counted.
- R4: Both counts saturate at 15 and never wrap.
- R5: hit_o goes to 1 on the edge that captures the first hit. It then stays at 1 until a clear. A second rising edge in the same window changes neither hit_o nor either count.
- R6: A rising comparator edge sampled while shutter_i is low has no effect. A pulse that is already high when the shutter opens is not a hit.
- R7: clear_i high on an edge sets both counts and hit_o to zero. It wins over a rising edge sampled on the same cycle, and it leaves trim_o unchanged.
- R8: load_i high on an edge copies the state held before that edge into rd_word_o: bit 8 is the hit flag, bits 7:4 the arrival count and bits 3:0 the duration count. Without load_i, rd_word_o holds its value.
- R9: cfg_we_i high on an edge stores cfg_trim_i into trim_o. Otherwise trim_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| disc_i | input | 1 | Synchronized comparator output |
| shutter_i | input | 1 | Exposure window, high while open |
| clear_i | input | 1 | Synchronous clear of counts and flag |
| load_i | input | 1 | Parallel load into the readout register |
| cfg_we_i | input | 1 | Trim code write strobe |
| cfg_trim_i | input | 4 | Trim code to store |
| hit_o | output | 1 | Live hit flag |
| rd_word_o | output | 9 | Readout register {flag, arrival, duration} |
| trim_o | output | 4 | Stored threshold-trim code |

## Verification
The bench uses the default widths: 4-bit counts and a 4-bit trim code. With these widths, saturation is reached within sixteen cycles of an open shutter, so both the directed long-pulse case and the longer random windows actually pin the counts at 15. The random phase uses shutter windows of varying length, sparse clears and loads, and comparator pulses of random length. This mixes second pulses, pulses that straddle the shutter edges and clears that coincide with edges.

// File: rtl/pix_pkg.sv
package pix_pkg;
  localparam int unsigned PIX_CNT_W  = 4;
  localparam int unsigned PIX_TRIM_W = 4;

  // measurement phase of a cell within one shutter window
  typedef enum logic [1:0] {
    PX_ARMED = 2'd0,  // waiting for first crossing
    PX_PULSE = 2'd1,  // both counts running
    PX_TAIL  = 2'd2,  // pulse over, arrival still running
    PX_DONE  = 2'd3   // window closed, counts frozen
  } px_state_e;
endpackage

// File: rtl/pix_edge_det.sv
module pix_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/pix_sat_cnt.sv
module pix_sat_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         start_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (start_i)               cnt_q <= ONE;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pix_cfg_reg.sv
module pix_cfg_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/pix_hit_capture.sv
module pix_hit_capture #(
  parameter int unsigned CNT_W  = pix_pkg::PIX_CNT_W,
  parameter int unsigned TRIM_W = pix_pkg::PIX_TRIM_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 disc_i,
  input  logic                 shutter_i,
  input  logic                 clear_i,
  input  logic                 load_i,
  input  logic                 cfg_we_i,
  input  logic [TRIM_W-1:0]    cfg_trim_i,
  output logic                 hit_o,
  output logic [2*CNT_W:0]     rd_word_o,
  output logic [TRIM_W-1:0]    trim_o
);
  import pix_pkg::*;

  localparam int unsigned WORD_W = 2 * CNT_W + 1;

  px_state_e        state_q, state_d;
  logic             rise;
  logic             arm;
  logic             toa_inc, tot_inc;
  logic [CNT_W-1:0] toa_cnt, tot_cnt;
  logic [WORD_W-1:0] word_q;

  pix_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (disc_i),
    .rise_o (rise)
  );

  assign arm = shutter_i & rise & (state_q == PX_ARMED);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PX_ARMED: if (arm) state_d = PX_PULSE;
      PX_PULSE: begin
        if (!shutter_i)   state_d = PX_DONE;
        else if (!disc_i) state_d = PX_TAIL;
      end
      PX_TAIL:  if (!shutter_i) state_d = PX_DONE;
      PX_DONE:  state_d = PX_DONE;
      default:  state_d = PX_ARMED;
    endcase
    if (clear_i) state_d = PX_ARMED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PX_ARMED;
    else         state_q <= state_d;
  end

  assign toa_inc = shutter_i & ((state_q == PX_PULSE) | (state_q == PX_TAIL));
  assign tot_inc = shutter_i & disc_i & (state_q == PX_PULSE);

  pix_sat_cnt #(.W(CNT_W)) u_toa (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clear_i),
    .start_i (arm),
    .inc_i   (toa_inc),
    .cnt_o   (toa_cnt)
  );

  pix_sat_cnt #(.W(CNT_W)) u_tot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clear_i),
    .start_i (arm),
    .inc_i   (tot_inc),
    .cnt_o   (tot_cnt)
  );

  assign hit_o = (state_q != PX_ARMED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (load_i) word_q <= {hit_o, toa_cnt, tot_cnt};
  end

  assign rd_word_o = word_q;

  pix_cfg_reg #(.W(TRIM_W)) u_trim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .d_i    (cfg_trim_i),
    .q_o    (trim_o)
  );
endmodule

// File: rtl/pix_hit_capture_chk.sv
module pix_hit_capture_chk #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned TRIM_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              shutter_i,
  input logic              clear_i,
  input logic              load_i,
  input logic              cfg_we_i,
  input logic              hit_o,
  input logic [2*CNT_W:0]  rd_word_o,
  input logic [TRIM_W-1:0] trim_o,
  input logic [CNT_W-1:0]  toa_cnt,
  input logic [CNT_W-1:0]  tot_cnt
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toa_cnt == MAX && !clear_i) |=> toa_cnt == MAX);

  assert_tot_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tot_cnt == MAX && !clear_i) |=> tot_cnt == MAX);

  assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !clear_i) |=> hit_o);

  assert_closed_no_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shutter_i && !hit_o) |=> !hit_o);

  assert_clear_zeroes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (!hit_o && toa_cnt == '0 && tot_cnt == '0));

  assert_word_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> rd_word_o[2*CNT_W] == $past(hit_o));

  assert_word_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(rd_word_o));

  assert_trim_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(trim_o));
endmodule

bind pix_hit_capture pix_hit_capture_chk #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .shutter_i (shutter_i),
  .clear_i   (clear_i),
  .load_i    (load_i),
  .cfg_we_i  (cfg_we_i),
  .hit_o     (hit_o),
  .rd_word_o (rd_word_o),
  .trim_o    (trim_o),
  .toa_cnt   (toa_cnt),
  .tot_cnt   (tot_cnt)
);

// File: tb/tb_pix_hit_capture.sv
module tb_pix_hit_capture;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       disc_i = 1'b0, shutter_i = 1'b0, clear_i = 1'b0, load_i = 1'b0, cfg_we_i = 1'b0;
  logic [3:0] cfg_trim_i = 4'h0;
  logic       hit_o;
  logic [8:0] rd_word_o;
  logic [3:0] trim_o;

  int checks = 0;
  int fails  = 0;

  // reference state, built from the requirements
  logic       m_hit = 0, m_pulse = 0, m_run = 0, m_dq = 0;
  logic [3:0] m_toa = 0, m_tot = 0, m_trim = 0;
  logic [8:0] m_word = 0;

  always #4 clk_i = ~clk_i;

  pix_hit_capture dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .disc_i(disc_i), .shutter_i(shutter_i),
    .clear_i(clear_i), .load_i(load_i), .cfg_we_i(cfg_we_i), .cfg_trim_i(cfg_trim_i),
    .hit_o(hit_o), .rd_word_o(rd_word_o), .trim_o(trim_o)
  );

  function automatic logic [3:0] sat(input logic [3:0] v);
    return (v == 4'hF) ? v : v + 4'd1;
  endfunction

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input logic sh, input logic d, input logic clr,
                       input logic ld, input logic we, input logic [3:0] tr);
    logic rise;
    rise = d & ~m_dq;
    if (ld) m_word = {m_hit, m_toa, m_tot};
    if (we) m_trim = tr;
    if (clr) begin
      m_hit = 0; m_toa = 0; m_tot = 0; m_pulse = 0; m_run = 0;
    end else if (sh && rise && !m_hit) begin
      m_hit = 1; m_toa = 1; m_tot = 1; m_pulse = 1; m_run = 1;
    end else begin
      if (m_run && sh) m_toa = sat(m_toa);
      if (!sh) m_run = 0;
      if (m_pulse && d && sh) m_tot = sat(m_tot);
      else m_pulse = 0;
    end
    m_dq = d;
  endtask

  task automatic cyc(input logic sh, input logic d, input logic clr = 0,
                     input logic ld = 0, input logic we = 0, input logic [3:0] tr = 4'h0);
    shutter_i = sh; disc_i = d; clear_i = clr; load_i = ld; cfg_we_i = we; cfg_trim_i = tr;
    @(posedge clk_i);
    model(sh, d, clr, ld, we, tr);
    #2;
    chk("R5 hit flag", {8'h0, hit_o}, {8'h0, m_hit});
    chk("R8 readout word", rd_word_o, m_word);
    chk("R9 trim", {5'h0, trim_o}, {5'h0, m_trim});
  endtask

  task automatic load_chk(input string tag, input logic [8:0] exp);
    cyc(0, 0, 0, 1);
    chk(tag, rd_word_o, exp);
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1ce5));
    #21;
    chk("R1 word in reset", rd_word_o, 9'h000);
    chk("R1 flag in reset", {8'h0, hit_o}, 9'h000);
    chk("R1 trim in reset", {5'h0, trim_o}, 9'h000);
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    chk("R1 word at release", rd_word_o, 9'h000);

    // R9 trim write then hold
    cyc(0, 0, 0, 0, 1, 4'hA);
    chk("R9 write", {5'h0, trim_o}, 9'h00A);
    cyc(0, 0, 0, 0, 0, 4'h5);
    chk("R9 hold", {5'h0, trim_o}, 9'h00A);

    // R2/R3 basic hit: 3 high, 4 more shutter cycles
    cyc(0, 0, 1);
    cyc(1, 0); cyc(1, 0);
    repeat (3) cyc(1, 1);
    chk("R5 flag set", {8'h0, hit_o}, 9'h001);
    repeat (4) cyc(1, 0);
    cyc(0, 0);
    load_chk("R2 R3 R8 basic word", 9'h173);
    cyc(0, 0);
    chk("R8 word held", rd_word_o, 9'h173);

    // R5/R3 second pulse ignored
    cyc(0, 0, 1);
    cyc(1, 1); cyc(1, 1); cyc(1, 0); cyc(1, 1); cyc(1, 1); cyc(1, 0);
    cyc(0, 0);
    load_chk("R5 second pulse ignored", 9'h162);

    // R2 shutter reopen without clear: arrival stays frozen
    cyc(1, 0); cyc(1, 0);
    load_chk("R2 frozen after close", 9'h162);

    // R4 saturation
    cyc(0, 0, 1);
    repeat (20) cyc(1, 1);
    cyc(0, 0);
    load_chk("R4 saturate", 9'h1FF);

    // R6 edge with shutter closed, and pulse already high at open
    cyc(0, 0, 1);
    cyc(0, 1); cyc(0, 1); cyc(0, 0);
    chk("R6 closed edge", {8'h0, hit_o}, 9'h000);
    cyc(0, 1);
    repeat (3) cyc(1, 1);
    cyc(1, 0); cyc(1, 0); cyc(0, 0);
    load_chk("R6 pre-open pulse", 9'h000);

    // R3 duration stops at shutter close
    cyc(0, 0, 1);
    cyc(1, 1); cyc(1, 1); cyc(0, 1); cyc(0, 1); cyc(0, 0);
    load_chk("R3 stop at close", 9'h122);

    // R7 clear wins over simultaneous edge, keeps trim
    cyc(1, 0);
    cyc(1, 1, 1);
    chk("R7 clear beats edge", {8'h0, hit_o}, 9'h000);
    cyc(1, 1);
    chk("R7 no late hit", {8'h0, hit_o}, 9'h000);
    cyc(1, 0); cyc(1, 1); cyc(1, 0);
    cyc(1, 0, 1);
    chk("R7 clear after hit", {8'h0, hit_o}, 9'h000);
    chk("R7 trim kept", {5'h0, trim_o}, 9'h00A);
    cyc(0, 0);
    load_chk("R7 counts zero", 9'h000);

    // random phase
    for (int w = 0; w < 150; w++) begin
      int open_len;
      logic d;
      open_len = 2 + int'($urandom_range(0, 24));
      cyc(0, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0));
      d = 1'($urandom_range(0, 1));
      for (int c = 0; c < open_len; c++) begin
        if ($urandom_range(0, 3) == 0) d = ~d;
        cyc(1, d, ($urandom_range(0, 40) == 0), ($urandom_range(0, 15) == 0),
            ($urandom_range(0, 20) == 0), 4'($urandom));
      end
      cyc(0, 1'($urandom_range(0, 1)), 0, 1);
      chk("R2 R3 R8 random word", rd_word_o, m_word);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule